// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Phase Tracker

This block steers the sampling phase of a serial receiver. Once per received bit, a front end delivers a data sample and an edge sample taken midway between that bit and the one before it, together with a valid strobe. Whenever two consecutive data bits differ, the edge sample shows which of the two bits it agrees with. That reveals whether the recovered clock sits late or early. The decision is only binary, so it carries no measure of how far off the clock is.

Each decision is a unit error of +1 or -1. It passes through a proportional-plus-integral loop filter. The proportional path adds a fixed step of `2**KP_SH`. The integral path adds a saturating accumulator of past decisions, shifted right by `KI_SH`. The integral path lets the loop follow a steady frequency offset between the transmitter and the receiver.

The filtered step updates a phase code of `log2(PHASES)+WBITS` bits. The upper field selects a pair of adjacent reference phases. The lower field is the interpolation weight between the two phases of that pair. Arithmetic on the code is modulo its full range, so the phase can rotate through 360 degrees any number of times. A lock flag is refreshed at the end of each window of `LOCK_WIN` valid bits.

Top module: `bbcdr_tracker`

## Requirements
- R1: While reset is asserted, `phase_sel` and `interp_wt` are 0 and `locked` is 0.
- R2: A valid bit whose data equals the previous valid bit's data produces no decision. The first valid bit after reset also produces no decision. In both cases the phase code and the integral accumulator stay unchanged.
- R3: On a valid bit whose data differs from the previous one, if the edge sample equals the new data bit, the clock is late. The error is -1 and the phase moves down.
- R4: On a valid bit whose data differs from the previous one, if the edge sample equals the previous data bit, the clock is early. The error is +1 and the phase moves up.
- R5: On a decision, the accumulator first takes the error. The phase code then changes by `err*2**KP_SH + (acc >>> KI_SH)`, where `acc` is the updated accumulator value. The result is visible one clock after the sample.
- R6: The integral accumulator saturates at the most positive and most negative `ACC_W`-bit values and never wraps.
- R7: The phase code is `{phase_sel, interp_wt}`, taken modulo `PHASES*2**WBITS` (PHASES is a power of two). A weight that moves past its maximum wraps toward 0 and `phase_sel` increments. A weight that moves below 0 wraps toward its maximum and `phase_sel` decrements. `phase_sel` itself wraps between `PHASES-1` and 0.
- R8: While `smp_vld` is low, the data and edge inputs have no effect on any output or loop state.
- R9: Every `LOCK_WIN`-th valid bit closes a window. `locked` is then set to whether the net error sum (early minus late) over that window lies within ±`LOCK_THR`. `locked` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Samples on this cycle are valid |
| smp_data | input | 1 | Data sample of the current bit |
| smp_edge | input | 1 | Edge sample between the previous and the current bit |
| phase_sel | output | $clog2(PHASES) | Index of the selected adjacent phase pair |
| interp_wt | output | WBITS | Interpolation weight within the pair |
| locked | output | 1 | Loop judged settled over the last window |

## Verification
The bench first sends runs of repeated bits. These separate true transitions from mere valid strobes. Toggling inputs while the strobe is low then shows that idle cycles are ignored. Long early-only and late-only streams come next. They drive the code across weight and pair boundaries in both directions and push the accumulator into saturation, so that the growing step size exposes any error in the integral path or the clamp. Balanced alternating early and late decisions must raise the lock flag. A one-sided stream must drop it, and the flag may change only at window boundaries.

// File: rtl/bbcdr_tracker.sv
module bbcdr_tracker #(
  parameter int PHASES   = 8,
  parameter int WBITS    = 4,
  parameter int ACC_W    = 8,
  parameter int KP_SH    = 1,
  parameter int KI_SH    = 3,
  parameter int LOCK_WIN = 16,
  parameter int LOCK_THR = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_vld,
  input  logic                      smp_data,
  input  logic                      smp_edge,
  output logic [$clog2(PHASES)-1:0] phase_sel,
  output logic [WBITS-1:0]          interp_wt,
  output logic                      locked
);
  localparam int PSEL_W = $clog2(PHASES);
  localparam int CODE_W = PSEL_W + WBITS;
  localparam int SW     = CODE_W + ACC_W + 2;
  localparam int CNT_W  = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1;
  localparam int NET_W  = $clog2(LOCK_WIN + 1) + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [SW-1:0]    KP_STEP = SW'(1) << KP_SH;
  localparam logic signed [NET_W-1:0] THR     = NET_W'(LOCK_THR);

  logic                     prev_d, have_prev;
  logic signed [ACC_W-1:0]  acc, acc_nxt;
  logic [CODE_W-1:0]        code;
  logic [CNT_W-1:0]         win_cnt;
  logic signed [NET_W-1:0]  net, net_nxt;
  logic                     lock_q;
  logic signed [1:0]        err;
  logic signed [SW-1:0]     acc_ext, step;

  wire decide  = smp_vld && have_prev && (smp_data != prev_d);
  wire late    = (smp_edge == smp_data);
  wire win_end = smp_vld && (win_cnt == CNT_W'(LOCK_WIN - 1));

  assign err = decide ? (late ? -2'sd1 : 2'sd1) : 2'sd0;

  always_comb begin
    if (err > 0 && acc == ACC_MAX)      acc_nxt = acc;
    else if (err < 0 && acc == ACC_MIN) acc_nxt = acc;
    else                                acc_nxt = acc + ACC_W'(err);
  end

  assign acc_ext = SW'(acc_nxt);
  assign step    = (late ? -KP_STEP : KP_STEP) + (acc_ext >>> KI_SH);
  assign net_nxt = net + NET_W'(err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_d    <= 1'b0;
      have_prev <= 1'b0;
      acc       <= '0;
      code      <= '0;
    end else if (smp_vld) begin
      prev_d    <= smp_data;
      have_prev <= 1'b1;
      if (decide) begin
        acc  <= acc_nxt;
        code <= code + step[CODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      net     <= '0;
      lock_q  <= 1'b0;
    end else if (smp_vld) begin
      if (win_end) begin
        win_cnt <= '0;
        net     <= '0;
        lock_q  <= (net_nxt <= THR) && (net_nxt >= -THR);
      end else begin
        win_cnt <= win_cnt + 1'b1;
        net     <= net_nxt;
      end
    end
  end

  assign phase_sel = code[CODE_W-1:WBITS];
  assign interp_wt = code[WBITS-1:0];
  assign locked    = lock_q;
endmodule

// File: rtl/bbcdr_tracker_chk.sv
module bbcdr_tracker_chk #(
  parameter int PSEL_W   = 3,
  parameter int WBITS    = 4,
  parameter int ACC_W    = 8,
  parameter int CNT_W    = 4,
  parameter int LOCK_WIN = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_vld,
  input logic                    smp_data,
  input logic                    prev_d,
  input logic                    have_prev,
  input logic signed [ACC_W-1:0] acc,
  input logic [PSEL_W-1:0]       phase_sel,
  input logic [WBITS-1:0]        interp_wt,
  input logic                    locked,
  input logic [CNT_W-1:0]        win_cnt
);
  localparam logic signed [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] AMIN = {1'b1, {(ACC_W-1){1'b0}}};

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (phase_sel == '0 && interp_wt == '0 && !locked));

  assert_no_transition_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (!have_prev || smp_data == prev_d))
      |=> ($stable(phase_sel) && $stable(interp_wt) && $stable(acc)));

  assert_acc_no_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == AMAX) |=> (acc != AMIN));

  assert_acc_no_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == AMIN) |=> (acc != AMAX));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(phase_sel) && $stable(interp_wt) && $stable(locked) && $stable(acc)));

  assert_lock_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld || win_cnt != CNT_W'(LOCK_WIN - 1)) |=> $stable(locked));
endmodule

bind bbcdr_tracker bbcdr_tracker_chk #(
  .PSEL_W(PSEL_W), .WBITS(WBITS), .ACC_W(ACC_W), .CNT_W(CNT_W), .LOCK_WIN(LOCK_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
  .prev_d(prev_d), .have_prev(have_prev), .acc(acc),
  .phase_sel(phase_sel), .interp_wt(interp_wt), .locked(locked), .win_cnt(win_cnt)
);

// File: tb/sim_bbcdr_tracker.sv
module sim_bbcdr_tracker;
  localparam int PHASES = 8, WBITS = 4, ACC_W = 8, KP_SH = 1, KI_SH = 3;
  localparam int LOCK_WIN = 16, LOCK_THR = 2;
  localparam int CODE_N = PHASES * (1 << WBITS);
  localparam int AMAX = (1 << (ACC_W - 1)) - 1;
  localparam int AMIN = -(1 << (ACC_W - 1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_vld = 1'b0, smp_data = 1'b0, smp_edge = 1'b0;
  logic [2:0] phase_sel;
  logic [WBITS-1:0] interp_wt;
  logic locked;

  bbcdr_tracker #(.PHASES(PHASES), .WBITS(WBITS), .ACC_W(ACC_W), .KP_SH(KP_SH),
    .KI_SH(KI_SH), .LOCK_WIN(LOCK_WIN), .LOCK_THR(LOCK_THR)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .smp_edge(smp_edge), .phase_sel(phase_sel), .interp_wt(interp_wt), .locked(locked));

  always #2 clk = ~clk;

  typedef struct { int sel; int wt; bit lk; string tag; } exp_t;
  exp_t q[$];
  int vectors = 0, fails = 0;
  bit done = 0;

  int m_acc = 0, m_code = 0, m_cnt = 0, m_net = 0;
  bit m_prev = 0, m_have = 0, m_lock = 0;
  bit saw_sat = 0;

  task automatic drive(input bit v, input bit d, input bit e, input string tag);
    int err;
    exp_t x;
    @(negedge clk);
    smp_vld = v; smp_data = d; smp_edge = e;
    if (v) begin
      err = 0;
      if (m_have && d != m_prev) err = (e == d) ? -1 : 1;
      if (err != 0) begin
        m_acc = m_acc + err;
        if (m_acc > AMAX) m_acc = AMAX;
        if (m_acc < AMIN) m_acc = AMIN;
        if (m_acc == AMAX) saw_sat = 1;
        m_code = ((m_code + err * (1 << KP_SH) + (m_acc >>> KI_SH)) % CODE_N + CODE_N) % CODE_N;
      end
      m_net = m_net + err;
      if (m_cnt == LOCK_WIN - 1) begin
        m_lock = (m_net <= LOCK_THR) && (m_net >= -LOCK_THR);
        m_cnt = 0; m_net = 0;
      end else m_cnt++;
      m_prev = d; m_have = 1;
    end
    x.sel = m_code >> WBITS; x.wt = m_code % (1 << WBITS); x.lk = m_lock; x.tag = tag;
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      vectors++;
      if (int'(phase_sel) != x.sel || int'(interp_wt) != x.wt || locked != x.lk) begin
        fails++;
        $display("FAIL %s: got sel=%0d wt=%0d lock=%0d, expected sel=%0d wt=%0d lock=%0d",
                 x.tag, phase_sel, interp_wt, locked, x.sel, x.wt, x.lk);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit d;
    repeat (3) @(negedge clk);
    vectors++;
    if (phase_sel != 0 || interp_wt != 0 || locked != 0) begin
      fails++;
      $display("FAIL R1: got sel=%0d wt=%0d lock=%0d, expected 0 0 0", phase_sel, interp_wt, locked);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: first bit and repeated bits make no decision
    drive(1, 1, 0, "R2");
    for (int i = 0; i < 5; i++) drive(1, 1, i[0], "R2");
    // R8: toggling inputs with valid low
    for (int i = 0; i < 6; i++) drive(0, i[0], ~i[0], "R8");

    // R4/R5/R7: early stream, rotates upward through pair boundaries
    d = 1;
    for (int i = 0; i < 60; i++) begin drive(1, ~d, d, "R4_R5_R7"); d = ~d; end
    // R6: keep pushing early until saturation, then beyond
    for (int i = 0; i < 200; i++) begin drive(1, ~d, d, "R6"); d = ~d; end
    if (!saw_sat) begin fails++; $display("FAIL R6: got no saturation, expected saturation"); end
    vectors++;
    // R3/R7: late stream, drives accumulator down and rotates backward
    for (int i = 0; i < 400; i++) begin drive(1, ~d, ~d, "R3_R6_R7"); d = ~d; end
    // R2 again with nonzero accumulator: repeats do not move the phase
    for (int i = 0; i < 8; i++) drive(1, d, ~d, "R2");
    // R8 again with nonzero accumulator
    for (int i = 0; i < 8; i++) drive(0, ~d, i[1], "R8");

    // R9: balanced early/late decisions raise lock at window end
    for (int i = 0; i < 4 * LOCK_WIN; i++) begin
      drive(1, ~d, i[0] ? ~d : d, "R9");
      d = ~d;
    end
    // R9: one-sided stream drops lock at next window end
    for (int i = 0; i < 2 * LOCK_WIN; i++) begin drive(1, ~d, d, "R9"); d = ~d; end
    // R9: mixed with idle cycles, lock only changes on window end
    for (int i = 0; i < 3 * LOCK_WIN; i++) begin
      if (i % 3 == 2) drive(0, 1, 1, "R8_R9");
      else begin drive(1, ~d, i[0] ? ~d : d, "R9"); d = ~d; end
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule